// File: doc/BRIEF.md
# Disk DMA Handshake Strobe Timer

This block drives the device side of a parallel disk interface during DMA bursts and single programmed I/O (PIO) words. It runs on the host bus clock. It answers the device's DMA request with an acknowledge, and it times the active-low read or write strobe from per-drive cycle counts. It also pulses a done signal for each word moved. The data bus drivers and the descriptor engine sit outside this block. They use the done pulse to advance.

Each drive has a base timing set, made of an active count and a recovery count, plus a fast set and a fast-enable bit. PIO words always use the base set. A DMA burst uses the fast set when that drive's fast-enable bit is set, and the base set otherwise. The device request is sampled on the very clock edge that ends each strobe. The answer decides whether the burst carries on or the acknowledge is released. A channel-enable input aborts any activity at once.

Top module: `dsk_dma_hs`

## Requirements
- R1: While reset is held and after it is released with no stimulus, dma_ack is 0, rd_n and wr_n are 1 and word_done is 0.
- R2: When the block is idle and enabled, a clock edge that samples dev_req high sets dma_ack. No strobe is active on that first acknowledge cycle, and the first strobe starts on the next edge.
- R3: A strobe stays low for N+1 clocks, where N (0 to 15) is the selected 4-bit active count. With dir_rd = 1 the strobe is rd_n, with dir_rd = 0 it is wr_n, and the two are never low together.
- R4: Inside a burst, dma_ack stays high and the strobes stay high for M+1 clocks, where M is the selected recovery count, between one strobe and the next.
- R5: dev_req is sampled on the edge where a DMA strobe deasserts. If it is high there, another word follows after the recovery time.
- R6: If dev_req is low at that sample, dma_ack falls one clock later. No further strobe occurs until dev_req is seen high again while idle.
- R7: A DMA burst uses drive drv_sel's fast active and recovery counts when bit drv_sel of fast_dma_en is 1, and that drive's base counts when it is 0. Each drive's fields occupy bits [4*d+3:4*d] of the count buses.
- R8: pio_go, sampled high while idle and enabled with dev_req low, runs one strobe with the drive's base counts, whatever its fast-enable bit. dma_ack stays low for the whole word. The block returns to idle once the base recovery time ends.
- R9: word_done is high for exactly the one clock that follows the edge on which a completed strobe deasserts, for DMA and PIO words alike.
- R10: chan_en sampled low forces dma_ack to 0, both strobes to 1 and word_done to 0 after that edge. Requests are ignored while it stays low.
- R11: If dev_req and pio_go are both high in idle, the DMA request wins.
- R12: The timing counts and direction are captured when a burst or PIO word starts. Changes to them mid-burst have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low aborts and holds idle |
| dev_req | input | 1 | Device DMA request, active high |
| pio_go | input | 1 | Start one PIO word |
| dir_rd | input | 1 | 1 = read from device (rd_n), 0 = write (wr_n) |
| drv_sel | input | 1 | Selected drive |
| base_act | input | 8 | Base active counts, 4 bits per drive |
| base_rec | input | 8 | Base recovery counts, 4 bits per drive |
| fast_act | input | 8 | DMA-only fast active counts, 4 bits per drive |
| fast_rec | input | 8 | DMA-only fast recovery counts, 4 bits per drive |
| fast_dma_en | input | 2 | Per-drive enable for the fast DMA set |
| dma_ack | output | 1 | DMA acknowledge to the device |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| word_done | output | 1 | One-clock pulse per completed word |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that chan_en, dev_req, pio_go and the timing buses change only between clock edges, so the strobe-versus-acknowledge relations they check are never corrupted by a mid-cycle input. The stimulus drives every input on the falling edge and holds it stable across the rising edge. It changes the timing buses and direction in the middle of a burst only to exercise the capture-at-start rule.

// File: rtl/dsk_dma_pkg.sv
package dsk_dma_pkg;

  typedef enum logic [2:0] {
    HS_IDLE  = 3'd0,
    HS_SETUP = 3'd1,
    HS_DSTRB = 3'd2,
    HS_DREC  = 3'd3,
    HS_HALT  = 3'd4,
    HS_PSTRB = 3'd5,
    HS_PREC  = 3'd6
  } hs_state_e;

endpackage

// File: rtl/dsk_dma_tsel.sv
module dsk_dma_tsel #(
  parameter int NDRV = 2,
  parameter int CW   = 4,
  localparam int DW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic [DW-1:0]      drv,
  input  logic [NDRV*CW-1:0] base_act,
  input  logic [NDRV*CW-1:0] base_rec,
  input  logic [NDRV*CW-1:0] fast_act,
  input  logic [NDRV*CW-1:0] fast_rec,
  input  logic [NDRV-1:0]    fast_en,
  output logic [CW-1:0]      dma_act,
  output logic [CW-1:0]      dma_rec,
  output logic [CW-1:0]      pio_act,
  output logic [CW-1:0]      pio_rec
);

  logic [CW-1:0] d_act [NDRV];
  logic [CW-1:0] d_rec [NDRV];
  logic [CW-1:0] p_act [NDRV];
  logic [CW-1:0] p_rec [NDRV];

  // per-drive choice between the base and the fast set
  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    assign p_act[g] = base_act[g*CW +: CW];
    assign p_rec[g] = base_rec[g*CW +: CW];
    assign d_act[g] = fast_en[g] ? fast_act[g*CW +: CW] : base_act[g*CW +: CW];
    assign d_rec[g] = fast_en[g] ? fast_rec[g*CW +: CW] : base_rec[g*CW +: CW];
  end

  assign dma_act = d_act[drv];
  assign dma_rec = d_rec[drv];
  assign pio_act = p_act[drv];
  assign pio_rec = p_rec[drv];

endmodule

// File: rtl/dsk_dma_cnt.sv
module dsk_dma_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dsk_dma_fsm.sv
module dsk_dma_fsm
  import dsk_dma_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          dev_req,
  input  logic          pio_go,
  input  logic          dir_rd,
  input  logic [CW-1:0] dma_act,
  input  logic [CW-1:0] dma_rec,
  input  logic [CW-1:0] pio_act,
  input  logic [CW-1:0] pio_rec,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          dma_ack,
  output logic          rd_n,
  output logic          wr_n,
  output logic          word_done
);

  hs_state_e     state_q, state_d;
  logic [CW-1:0] act_q, act_d, rec_q, rec_d;
  logic          dir_q, dir_d;
  logic          tim_en;
  logic          start_dma, start_pio;
  logic          done_d, ack_d, strb_d, rd_n_d, wr_n_d;

  // next-state decode
  always_comb begin
    state_d   = state_q;
    start_dma = 1'b0;
    start_pio = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = act_q;
    done_d    = 1'b0;
    if (!chan_en) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (dev_req) begin
            state_d   = HS_SETUP;
            start_dma = 1'b1;
          end else if (pio_go) begin
            state_d   = HS_PSTRB;
            start_pio = 1'b1;
            cnt_load  = 1'b1;
            cnt_val   = pio_act;
          end
        end
        HS_SETUP: begin
          state_d  = HS_DSTRB;
          cnt_load = 1'b1;
          cnt_val  = act_q;
        end
        HS_DSTRB: begin
          if (cnt_zero) begin
            done_d = 1'b1;
            if (dev_req) begin
              state_d  = HS_DREC;
              cnt_load = 1'b1;
              cnt_val  = rec_q;
            end else begin
              state_d = HS_HALT;
            end
          end
        end
        HS_DREC: begin
          if (cnt_zero) begin
            state_d  = HS_DSTRB;
            cnt_load = 1'b1;
            cnt_val  = act_q;
          end
        end
        HS_HALT: state_d = HS_IDLE;
        HS_PSTRB: begin
          if (cnt_zero) begin
            done_d   = 1'b1;
            state_d  = HS_PREC;
            cnt_load = 1'b1;
            cnt_val  = rec_q;
          end
        end
        HS_PREC: begin
          if (cnt_zero) state_d = HS_IDLE;
        end
        default: state_d = HS_IDLE;
      endcase
    end
  end

  // timing capture and output decode
  always_comb begin
    tim_en = start_dma | start_pio;
    act_d  = start_dma ? dma_act : pio_act;
    rec_d  = start_dma ? dma_rec : pio_rec;
    dir_d  = tim_en ? dir_rd : dir_q;
    strb_d = (state_d == HS_DSTRB) || (state_d == HS_PSTRB);
    ack_d  = (state_d == HS_SETUP) || (state_d == HS_DSTRB) ||
             (state_d == HS_DREC)  || (state_d == HS_HALT);
    rd_n_d = !(strb_d && dir_d);
    wr_n_d = !(strb_d && !dir_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      dma_ack   <= 1'b0;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      word_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      dma_ack   <= ack_d;
      rd_n      <= rd_n_d;
      wr_n      <= wr_n_d;
      word_done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rec_q <= '0;
      dir_q <= 1'b0;
    end else if (tim_en) begin
      act_q <= act_d;
      rec_q <= rec_d;
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/dsk_dma_hs.sv
module dsk_dma_hs #(
  parameter int NDRV = 2,
  parameter int CW   = 4,
  localparam int DW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               dev_req,
  input  logic               pio_go,
  input  logic               dir_rd,
  input  logic [DW-1:0]      drv_sel,
  input  logic [NDRV*CW-1:0] base_act,
  input  logic [NDRV*CW-1:0] base_rec,
  input  logic [NDRV*CW-1:0] fast_act,
  input  logic [NDRV*CW-1:0] fast_rec,
  input  logic [NDRV-1:0]    fast_dma_en,
  output logic               dma_ack,
  output logic               rd_n,
  output logic               wr_n,
  output logic               word_done
);

  logic [CW-1:0] dma_act, dma_rec, pio_act, pio_rec;
  logic [CW-1:0] cnt_val;
  logic          cnt_load, cnt_zero;

  dsk_dma_tsel #(.NDRV(NDRV), .CW(CW)) u_tsel (
    .drv      (drv_sel),
    .base_act (base_act),
    .base_rec (base_rec),
    .fast_act (fast_act),
    .fast_rec (fast_rec),
    .fast_en  (fast_dma_en),
    .dma_act  (dma_act),
    .dma_rec  (dma_rec),
    .pio_act  (pio_act),
    .pio_rec  (pio_rec)
  );

  dsk_dma_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  dsk_dma_fsm #(.CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .dev_req   (dev_req),
    .pio_go    (pio_go),
    .dir_rd    (dir_rd),
    .dma_act   (dma_act),
    .dma_rec   (dma_rec),
    .pio_act   (pio_act),
    .pio_rec   (pio_rec),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .dma_ack   (dma_ack),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .word_done (word_done)
  );

endmodule

// File: rtl/dsk_dma_chk.sv
module dsk_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic dma_ack,
  input logic rd_n,
  input logic wr_n,
  input logic word_done
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));

  // R10
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!dma_ack && rd_n && wr_n && !word_done));

  // R9
  done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> ($rose(rd_n) || $rose(wr_n)));

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack) |-> (!$past(chan_en) || $past(word_done)));

  // R2
  ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_ack) |-> (rd_n && wr_n));

endmodule

bind dsk_dma_hs dsk_dma_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .dma_ack   (dma_ack),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .word_done (word_done)
);

// File: tb/dsk_dma_hs_bench.sv
`timescale 1ns/100ps
module dsk_dma_hs_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chan_en, dev_req, pio_go, dir_rd;
  logic [0:0] drv_sel;
  logic [7:0] base_act, base_rec, fast_act, fast_rec;
  logic [1:0] fast_dma_en;
  logic       dma_ack, rd_n, wr_n, word_done;

  always #2.5 clk = ~clk;

  dsk_dma_hs u_dsk_dma_hs (
    .clk (clk), .rst_n (rst_n), .chan_en (chan_en), .dev_req (dev_req),
    .pio_go (pio_go), .dir_rd (dir_rd), .drv_sel (drv_sel),
    .base_act (base_act), .base_rec (base_rec), .fast_act (fast_act),
    .fast_rec (fast_rec), .fast_dma_en (fast_dma_en),
    .dma_ack (dma_ack), .rd_n (rd_n), .wr_n (wr_n), .word_done (word_done)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 ack-only, 2 dma strobe, 3 dma gap,
  // 4 ack release, 5 pio strobe, 6 pio gap
  int mode, left, m_act, m_rec;
  bit m_rd, e_ack, e_rd, e_wr, e_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; left = 0; m_act = 0; m_rec = 0; m_rd = 0;
    end else begin
      e_done = 0;
      if (!chan_en) mode = 0;
      else case (mode)
        0: if (dev_req) begin
             mode = 1; m_rd = dir_rd;
             m_act = fast_dma_en[drv_sel] ? fast_act[drv_sel*4 +: 4] : base_act[drv_sel*4 +: 4];
             m_rec = fast_dma_en[drv_sel] ? fast_rec[drv_sel*4 +: 4] : base_rec[drv_sel*4 +: 4];
           end else if (pio_go) begin
             mode = 5; m_rd = dir_rd;
             m_act = base_act[drv_sel*4 +: 4]; m_rec = base_rec[drv_sel*4 +: 4];
             left = m_act + 1;
           end
        1: begin mode = 2; left = m_act + 1; end
        2: begin left--; if (left == 0) begin e_done = 1;
             if (dev_req) begin mode = 3; left = m_rec + 1; end else mode = 4; end end
        3: begin left--; if (left == 0) begin mode = 2; left = m_act + 1; end end
        4: mode = 0;
        5: begin left--; if (left == 0) begin e_done = 1; mode = 6; left = m_rec + 1; end end
        6: begin left--; if (left == 0) mode = 0; end
        default: mode = 0;
      endcase
    end
    e_ack = (mode >= 1 && mode <= 4);
    e_rd  = !((mode == 2 || mode == 5) && m_rd);
    e_wr  = !((mode == 2 || mode == 5) && !m_rd);
    if (!rst_n) e_done = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison and strobe width / pulse bookkeeping
  int run_w = 0, last_w = 0, n_done = 0, n_rise = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk({dma_ack, rd_n, wr_n, word_done} == {e_ack, e_rd, e_wr, e_done}, tag,
          "ack/rd_n/wr_n/done", {dma_ack, rd_n, wr_n, word_done},
          {e_ack, e_rd, e_wr, e_done});
      if (word_done) n_done++;
      if (!(rd_n && wr_n)) run_w++;
      else if (run_w != 0) begin last_w = run_w; run_w = 0; n_rise++; end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
      summary();
    end
  end

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; chan_en = 0; dev_req = 0; pio_go = 0; dir_rd = 1; drv_sel = 0;
    base_act = 8'h52; base_rec = 8'h31; fast_act = 8'h00; fast_rec = 8'h00;
    fast_dma_en = 2'b00;
    cyc_n(3);
    chk(!dma_ack && rd_n && wr_n && !word_done, "R1", "reset outputs",
        {dma_ack, rd_n, wr_n, word_done}, 4'b0110);
    rst_n = 1; cyc_n(2);
    chk(!dma_ack && rd_n && wr_n, "R1", "idle after reset",
        {dma_ack, rd_n, wr_n}, 3'b011);

    // R2 / R5 / R4: read burst on drive 0, base act=2 rec=1
    chan_en = 1; tag = "R2"; dev_req = 1; cyc_n(1);
    chk(dma_ack && rd_n && wr_n, "R2", "ack first cycle",
        {dma_ack, rd_n, wr_n}, 3'b111);
    cyc_n(1);
    chk(!rd_n, "R2", "strobe next cycle", rd_n, 0);
    tag = "R5"; cyc_n(8); tag = "R4"; cyc_n(6);
    tag = "R6"; dev_req = 0; cyc_n(12);
    chk(last_w == 3, "R3", "read strobe width", last_w, 3);
    chk(!dma_ack && rd_n && wr_n, "R6", "no transfer without request",
        {dma_ack, rd_n, wr_n}, 3'b011);

    // R7: write burst, drive 1 fast set
    tag = "R7"; drv_sel = 1; dir_rd = 0; fast_dma_en = 2'b10;
    fast_act = 8'h00; fast_rec = 8'h00;
    dev_req = 1; cyc_n(8); dev_req = 0; cyc_n(8);
    chk(last_w == 1, "R7", "fast write width", last_w, 1);
    chk(n_done == n_rise, "R9", "done pulses per word", n_done, n_rise);

    // R8: PIO on drive 1 ignores fast set
    tag = "R8"; pio_go = 1; cyc_n(1); pio_go = 0;
    chk(!dma_ack, "R8", "no ack for pio", dma_ack, 0);
    cyc_n(16);
    chk(last_w == 6, "R8", "pio base width", last_w, 6);
    tag = "R9"; cyc_n(2);
    chk(n_done == n_rise, "R9", "done pulses per word", n_done, n_rise);

    // R3: maximum count
    tag = "R3"; drv_sel = 0; dir_rd = 1; base_act = 8'h5F; base_rec = 8'h30;
    dev_req = 1; cyc_n(3); dev_req = 0; cyc_n(24);
    chk(last_w == 16, "R3", "max strobe width", last_w, 16);

    // R12: change timing and direction mid-burst
    tag = "R12"; base_act = 8'h52; base_rec = 8'h31;
    dev_req = 1; cyc_n(3); base_act = 8'h59; dir_rd = 0; cyc_n(14);
    chk(last_w == 3 && wr_n, "R12", "captured timing kept", last_w, 3);
    dev_req = 0; cyc_n(12); dir_rd = 1;

    // R11: request wins over pio_go
    tag = "R11"; dev_req = 1; pio_go = 1; cyc_n(1); pio_go = 0;
    chk(dma_ack, "R11", "dma chosen", dma_ack, 1);
    cyc_n(4);

    // R10: disable mid-burst, request ignored while disabled
    tag = "R10"; chan_en = 0; cyc_n(1);
    chk(!dma_ack && rd_n && wr_n && !word_done, "R10", "abort",
        {dma_ack, rd_n, wr_n, word_done}, 4'b0110);
    cyc_n(5);
    chk(!dma_ack && rd_n && wr_n, "R10", "held idle",
        {dma_ack, rd_n, wr_n}, 3'b011);
    chan_en = 1; cyc_n(10); dev_req = 0; cyc_n(12);
    summary();
  end

endmodule